// File: doc/BRIEF.md
# Coprocessor Accept/Commit Responder

This block sits on the coprocessor side of a core-to-coprocessor handshake and answers data-operation requests. The core signals a request by pulling an active-low request line low and presents a coprocessor number. The responder answers on two active-low lines. The accept line claims the instruction. The commit line tells the core that the coprocessor has bound itself to perform the action. The core busy-waits for as long as accept is low and commit is high.

A request is recognised only when the request line is low and the presented number equals the `MATCH_ID` parameter. Whether the coprocessor can perform the operation is given by `capable_i`. Whether it can commit now depends on an external resource-busy input and on whether its own previous action is still running. On commit, the responder fires a one-cycle execute strobe in the next cycle. It then holds an internal busy indication for a programmable number of cycles, so the action finishes after the handshake has closed.

Top module: `cp_commit_responder`

## Requirements
- R1: While `cop_req_ni` is high, or `cp_num_i` differs from `MATCH_ID`, both `accept_n_o` and `commit_n_o` are high.
- R2: A matching request that has not already been claimed, presented while `capable_i` is low, leaves both response lines high.
- R3: A matching request with `capable_i` high, presented while the resource is not free, drives `accept_n_o` low and `commit_n_o` high. The resource is not free when `res_busy_i` is high or `exec_busy_o` is high.
- R4: `commit_n_o` is low only in a cycle where a claimed or capable matching request is present, `res_busy_i` is low and `exec_busy_o` is low. In such a cycle it is low in that same cycle, and `accept_n_o` is low with it.
- R5: Once a request has been claimed, `accept_n_o` stays low in every cycle the matching request remains present, whatever the value of `capable_i`, until the cycle in which `commit_n_o` goes low.
- R6: `exec_stb_o` is high for exactly the one cycle after each commit cycle and is low in every other cycle.
- R7: `exec_busy_o` is high for exactly N cycles, starting in the cycle after commit. N is the value of `exec_len_i` in the commit cycle, and a value of 0 is treated as 1.
- R8: A matching, capable request that arrives while `exec_busy_o` is high gets the not-ready response. It commits in the first cycle in which both `exec_busy_o` and `res_busy_i` are low.
- R9: If the request is withdrawn while waiting, both lines go high in that same cycle, the claim is dropped, and no strobe follows.
- R10: A claim ends with its commit cycle. A request present in the next cycle is a new request and needs `capable_i` high to be claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cop_req_ni | input | 1 | Active-low coprocessor instruction request from the core |
| cp_num_i | input | CPN_W | Coprocessor number carried by the instruction |
| capable_i | input | 1 | High when this coprocessor can perform the requested operation |
| res_busy_i | input | 1 | High while an external resource prevents committing |
| exec_len_i | input | LEN_W | Number of cycles the action occupies after commit |
| accept_n_o | output | 1 | Active-low accept (claim) response |
| commit_n_o | output | 1 | Active-low commit response |
| exec_stb_o | output | 1 | One-cycle execute strobe after commit |
| exec_busy_o | output | 1 | High while the committed action is executing |

## Verification
The assertions check several relations on every cycle. Both lines stay high with no matching request. Commit always comes with accept and never happens while the resource is busy. Accept is held through a wait. The strobe follows each commit by exactly one cycle and is never repeated. No commit is issued while an action runs. Only the bench scenarios can show the exact length of the busy window, including the zero-length case. They also cover the release of the claim after commit, the re-evaluation of `capable_i` on a back-to-back request, and the same-cycle drop of both lines when a waiting request is withdrawn.

// File: rtl/cp_resp_pkg.sv
package cp_resp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } hs_state_e;

  typedef struct packed {
    logic accept_n;
    logic commit_n;
  } resp_t;
endpackage

// File: rtl/cp_req_decode.sv
module cp_req_decode #(
  parameter int unsigned       CPN_W    = 4,
  parameter logic [CPN_W-1:0]  MATCH_ID = 4'd6
) (
  input  logic             cop_req_ni,
  input  logic [CPN_W-1:0] cp_num_i,
  input  logic             res_busy_i,
  input  logic             exec_busy_i,
  output logic             req_hit_o,
  output logic             res_free_o
);
  assign req_hit_o  = !cop_req_ni && (cp_num_i == MATCH_ID);
  assign res_free_o = !res_busy_i && !exec_busy_i;
endmodule

// File: rtl/cp_handshake_fsm.sv
module cp_handshake_fsm
  import cp_resp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_hit_i,
  input  logic  capable_i,
  input  logic  res_free_i,
  output resp_t resp_o,
  output logic  commit_o
);
  hs_state_e state_q, state_d;
  logic      claim;

  // a claimed request stays claimed while the core keeps it present
  assign claim    = req_hit_i && ((state_q == ST_WAIT) || capable_i);
  assign commit_o = claim && res_free_i;

  always_comb begin
    state_d = ST_IDLE;
    if (claim && !res_free_i) state_d = ST_WAIT;
  end

  always_comb begin
    resp_o.accept_n = !claim;
    resp_o.commit_n = !commit_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cp_exec_timer.sv
module cp_exec_timer #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             stb_o,
  output logic             busy_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, load_val;
  logic             stb_q;

  assign load_val = (len_i == '0) ? ONE : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= start_i;
      if (start_i)           cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end
  end

  assign stb_o  = stb_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cp_commit_responder.sv
module cp_commit_responder
  import cp_resp_pkg::*;
#(
  parameter int unsigned      CPN_W    = 4,
  parameter logic [CPN_W-1:0] MATCH_ID = 4'd6,
  parameter int unsigned      LEN_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cop_req_ni,
  input  logic [CPN_W-1:0] cp_num_i,
  input  logic             capable_i,
  input  logic             res_busy_i,
  input  logic [LEN_W-1:0] exec_len_i,
  output logic             accept_n_o,
  output logic             commit_n_o,
  output logic             exec_stb_o,
  output logic             exec_busy_o
);
  logic  req_hit, res_free, commit, exec_busy;
  resp_t resp;

  cp_req_decode #(.CPN_W(CPN_W), .MATCH_ID(MATCH_ID)) u_dec (
    .cop_req_ni  (cop_req_ni),
    .cp_num_i    (cp_num_i),
    .res_busy_i  (res_busy_i),
    .exec_busy_i (exec_busy),
    .req_hit_o   (req_hit),
    .res_free_o  (res_free)
  );

  cp_handshake_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_hit_i  (req_hit),
    .capable_i  (capable_i),
    .res_free_i (res_free),
    .resp_o     (resp),
    .commit_o   (commit)
  );

  cp_exec_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .len_i   (exec_len_i),
    .stb_o   (exec_stb_o),
    .busy_o  (exec_busy)
  );

  assign accept_n_o  = resp.accept_n;
  assign commit_n_o  = resp.commit_n;
  assign exec_busy_o = exec_busy;
endmodule

// File: rtl/cp_commit_responder_chk.sv
module cp_commit_responder_chk #(
  parameter int unsigned      CPN_W    = 4,
  parameter logic [CPN_W-1:0] MATCH_ID = 4'd6,
  parameter int unsigned      LEN_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cop_req_ni,
  input logic [CPN_W-1:0] cp_num_i,
  input logic             capable_i,
  input logic             res_busy_i,
  input logic [LEN_W-1:0] exec_len_i,
  input logic             accept_n_o,
  input logic             commit_n_o,
  input logic             exec_stb_o,
  input logic             exec_busy_o
);
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_req_ni || cp_num_i != MATCH_ID) |-> (accept_n_o && commit_n_o)); // R1

  AST_COMMIT_WITH_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_n_o |-> !accept_n_o); // R4

  AST_COMMIT_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_n_o |-> (!res_busy_i && !exec_busy_o)); // R4

  AST_ACCEPT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_n_o && commit_n_o) |=> (cop_req_ni || cp_num_i != MATCH_ID || !accept_n_o)); // R5

  AST_STB_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_n_o |=> (exec_stb_o && exec_busy_o)); // R6

  AST_STB_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_stb_o |-> $past(!commit_n_o)); // R6

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_stb_o |=> !exec_stb_o); // R6

  AST_NO_COMMIT_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_busy_o |-> commit_n_o); // R8
endmodule

bind cp_commit_responder cp_commit_responder_chk #(
  .CPN_W(CPN_W), .MATCH_ID(MATCH_ID), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/tb_cp_commit_responder.sv
module tb_cp_commit_responder;
  localparam int unsigned CPN_W = 4;
  localparam logic [3:0]  ID    = 4'd6;
  localparam int unsigned LEN_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cop_req_ni = 1'b1;
  logic [CPN_W-1:0] cp_num_i = '0;
  logic capable_i = 1'b0;
  logic res_busy_i = 1'b0;
  logic [LEN_W-1:0] exec_len_i = '0;
  logic accept_n_o, commit_n_o, exec_stb_o, exec_busy_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int rem = 0;
  bit wait_m = 0;
  bit stb_m = 0;

  always #5 clk = ~clk;

  cp_commit_responder #(.CPN_W(CPN_W), .MATCH_ID(ID), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cop_req_ni(cop_req_ni), .cp_num_i(cp_num_i),
    .capable_i(capable_i), .res_busy_i(res_busy_i), .exec_len_i(exec_len_i),
    .accept_n_o(accept_n_o), .commit_n_o(commit_n_o),
    .exec_stb_o(exec_stb_o), .exec_busy_o(exec_busy_o));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit rq_n, input logic [3:0] num, input bit cap,
                     input bit bsy, input int len);
    bit valid, free, claim, commit;
    string tag;
    @(negedge clk);
    cop_req_ni = rq_n; cp_num_i = num; capable_i = cap;
    res_busy_i = bsy; exec_len_i = LEN_W'(len);
    #2;
    valid  = !rq_n && (num == ID);
    free   = !bsy && (rem == 0);
    claim  = valid && (wait_m || cap);
    commit = claim && free;
    if (!valid)        tag = wait_m ? "R9" : "R1";
    else if (!claim)   tag = stb_m ? "R10" : "R2";
    else if (free)     tag = "R4";
    else if (rem > 0)  tag = "R8";
    else if (wait_m && !cap) tag = "R5";
    else               tag = "R3";
    chk(tag, "accept_n", accept_n_o, !claim);
    chk(tag, "commit_n", commit_n_o, !commit);
    chk("R6", "exec_stb", exec_stb_o, stb_m);
    chk("R7", "exec_busy", exec_busy_o, rem != 0);
    @(posedge clk);
    stb_m = commit;
    if (commit)       rem = (len == 0) ? 1 : len;
    else if (rem > 0) rem--;
    wait_m = claim && !free;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    #12;
    chk("R1", "reset accept_n", accept_n_o, 1'b1);
    chk("R1", "reset commit_n", commit_n_o, 1'b1);
    chk("R6", "reset stb", exec_stb_o, 1'b0);
    chk("R7", "reset busy", exec_busy_o, 1'b0);
    rst_ni = 1'b1;
    // R1: idle and mismatched number
    repeat (2) cyc(1, ID, 1, 0, 3);
    cyc(0, 4'd5, 1, 0, 3);
    cyc(0, 4'd7, 1, 0, 3);
    // R2: not capable
    repeat (2) cyc(0, ID, 0, 0, 3);
    // R4 R6 R7: immediate commit, length 3
    cyc(0, ID, 1, 0, 3);
    repeat (4) cyc(1, ID, 0, 0, 0);
    // R8: back-to-back request during execution
    cyc(0, ID, 1, 0, 2);
    repeat (3) cyc(0, ID, 1, 0, 2);
    repeat (3) cyc(1, ID, 0, 0, 0);
    // R3 R5: external busy, capability drops mid-wait
    cyc(0, ID, 1, 1, 4);
    cyc(0, ID, 0, 1, 4);
    cyc(0, ID, 0, 1, 4);
    cyc(0, ID, 0, 0, 4);
    repeat (5) cyc(1, ID, 0, 0, 0);
    // R9: withdraw while waiting, then re-present uncapable
    cyc(0, ID, 1, 1, 2);
    cyc(1, ID, 1, 1, 2);
    cyc(0, ID, 0, 0, 2);
    cyc(1, ID, 0, 0, 2);
    // R7: zero length treated as one
    cyc(0, ID, 1, 0, 0);
    repeat (2) cyc(1, ID, 0, 0, 0);
    // R10: request right after commit without capability
    cyc(0, ID, 1, 0, 1);
    cyc(0, ID, 0, 0, 1);
    cyc(0, ID, 0, 0, 1);
    cyc(1, ID, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) == 0, (($urandom % 4) == 0) ? 4'($urandom) : ID,
          ($urandom % 4) != 0, ($urandom % 3) == 0, int'($urandom % 6));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule